// File: doc/BRIEF.md
# Precise Exception Flush and Restart-PC Controller

This block decides, cycle by cycle, how a five-stage in-order pipeline with a single delayed-branch slot reacts to exceptional events. Four stages can raise a fault: fetch, decode, execute and memory. Each stage presents a valid bit, a fault bit and its instruction address. When faults appear, the controller services the deepest valid faulting instruction. It squashes that instruction and every younger one into bubbles, leaves the older instructions to retire, and records the address at which execution must restart. It then steers fetch to a fixed handler address.

When the faulting instruction sits in the delay slot of a branch, a second restart address (the branch destination resolved for that slot) is also recorded and marked valid. An external interrupt or trap cancels nothing: it records the supplied next-fetch address and steers fetch to the handler. A return-from-exception seen in the execute stage squashes the two instructions fetched behind it. Fetch then restarts at the first saved address and, one cycle later, at either the second saved address or the sequential successor of the first.

All control outputs are registered and appear one cycle after the triggering inputs. Stage index 0 is fetch, 1 decode, 2 execute and 3 memory. Higher indices hold older instructions.

Top module: `exc_flush_ctl`

## Requirements
- R1: After reset, `kill` is 0, `redir_vld` is 0, `epc0` and `epc1` are 0 and `epc1_vld` is 0.
- R2: When the deepest valid faulting stage is k, the next cycle shows `kill` bits 0..k set and bits above k clear, `redir_vld` 1 and `redir_pc` equal to the handler address (default 0x180).
- R3: When several stages fault together, the stage with the highest index is serviced. A fault bit whose stage valid bit is 0 has no effect.
- R4: On a serviced fault, `epc0` takes the faulting stage's PC. If that stage is not in a delay slot, `epc1_vld` is cleared.
- R5: On a serviced fault in a delay slot, `epc1` takes that stage's slot target and `epc1_vld` is set.
- R6: An interrupt request with no valid fault produces `kill` = 0, redirects to the handler, loads `epc0` with `irq_pc` and clears `epc1_vld`. A simultaneous valid fault takes priority over the interrupt.
- R7: A return-from-exception in execute produces, one cycle later, `kill` = 4'b0011 (fetch and decode) and a redirect to `epc0`.
- R8: In the following cycle `redir_vld` is 1. `redir_pc` is `epc1` when `epc1_vld` is 1, and `epc0`+4 otherwise. In the cycle after that, `redir_vld` is 0.
- R9: A valid fault in execute or memory wins over a return-from-exception in the same cycle. A fault in fetch or decode in that cycle is dropped in favour of the return.
- R10: Faults, interrupts and returns that arrive in the cycle in which a flush or the first return redirect is being applied are ignored. `epc0`, `epc1` and `epc1_vld` keep their values, and no redirect follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stg_vld | input | NSTG | Per-stage instruction valid (0 fetch .. 3 memory) |
| stg_exc | input | NSTG | Per-stage fault flag |
| stg_pc | input | NSTG x XLEN | Per-stage instruction address |
| stg_slot | input | NSTG | Per-stage flag: instruction is in a branch delay slot |
| slot_tgt | input | NSTG x XLEN | Per-stage resolved branch destination for a slot instruction |
| irq_req | input | 1 | External interrupt or trap request |
| irq_pc | input | XLEN | Next-fetch address to save on an interrupt |
| rfe_ex | input | 1 | Return-from-exception present in execute |
| kill | output | NSTG | Per-stage squash mask |
| redir_vld | output | 1 | Fetch redirect strobe |
| redir_pc | output | XLEN | Fetch redirect address |
| epc0 | output | XLEN | First saved restart PC |
| epc1 | output | XLEN | Second saved restart PC |
| epc1_vld | output | 1 | Second saved PC is meaningful |

## Verification
The bench targets priority corner cases. These include simultaneous faults in several stages, a fault from an invalid stage, and a return-from-exception that meets a fault either older or younger than itself. A design that got these wrong would save the wrong address or squash a retiring instruction. The bench faults in and out of a delay slot to catch a stale or missing second PC, which would resume at the wrong branch path. It runs both return endings to show whether the second redirect goes to the saved target or to the sequential successor. It injects new events during the applied flush to catch a design that lets a squashed instruction overwrite the saved PCs.

// File: rtl/xf_pkg.sv
package xf_pkg;

    // Control phase of the flush controller
    typedef enum logic [1:0] {
        XF_RUN   = 2'd0,   // accepting new events
        XF_APPLY = 2'd1,   // flush of a fault or interrupt is being applied
        XF_RET1  = 2'd2    // first redirect of a return is being applied
    } xf_phase_e;

endpackage

// File: rtl/xf_oldest.sv
// Finds the deepest (oldest) requesting stage and builds the squash mask
// covering that stage and every younger one.
module xf_oldest #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          hit,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  thru
);

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) idx = IW'(i);
        end
    end

    assign hit = |req;

    // A stage is squashed when it or any older stage is faulting
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_mask
            assign thru[g] = |req[N-1:g];
        end
    endgenerate

endmodule

// File: rtl/xf_epc.sv
// Saved restart-PC registers: one for the faulting instruction, one for the
// resolved branch destination when the fault sits in a delay slot.
module xf_epc #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld,
    input  logic [XLEN-1:0] ld_pc0,
    input  logic [XLEN-1:0] ld_pc1,
    input  logic            ld_pc1_vld,
    output logic [XLEN-1:0] epc0,
    output logic [XLEN-1:0] epc1,
    output logic            epc1_vld
);

    typedef struct packed {
        logic [XLEN-1:0] pc0;
        logic [XLEN-1:0] pc1;
        logic            pc1_vld;
    } epc_t;

    epc_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld) begin
            st_d.pc0     = ld_pc0;
            st_d.pc1_vld = ld_pc1_vld;
            if (ld_pc1_vld) st_d.pc1 = ld_pc1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign epc0     = st_q.pc0;
    assign epc1     = st_q.pc1;
    assign epc1_vld = st_q.pc1_vld;

endmodule

// File: rtl/exc_flush_ctl.sv
module exc_flush_ctl
    import xf_pkg::*;
#(
    parameter int          XLEN       = 32,
    parameter int          NSTG       = 4,
    parameter int          RFE_STG    = 2,
    parameter int          ILEN_B     = 4,
    parameter logic [31:0] HANDLER_PC = 32'h0000_0180
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NSTG-1:0]           stg_vld,
    input  logic [NSTG-1:0]           stg_exc,
    input  logic [NSTG-1:0][XLEN-1:0] stg_pc,
    input  logic [NSTG-1:0]           stg_slot,
    input  logic [NSTG-1:0][XLEN-1:0] slot_tgt,
    input  logic                      irq_req,
    input  logic [XLEN-1:0]           irq_pc,
    input  logic                      rfe_ex,
    output logic [NSTG-1:0]           kill,
    output logic                      redir_vld,
    output logic [XLEN-1:0]           redir_pc,
    output logic [XLEN-1:0]           epc0,
    output logic [XLEN-1:0]           epc1,
    output logic                      epc1_vld
);

    localparam int              IW       = (NSTG > 1) ? $clog2(NSTG) : 1;
    localparam logic [IW-1:0]   RFE_IDX  = IW'(RFE_STG);
    localparam logic [NSTG-1:0] RFE_KILL = NSTG'((1 << RFE_STG) - 1);
    localparam logic [XLEN-1:0] HDL_ADDR = XLEN'(HANDLER_PC);
    localparam logic [XLEN-1:0] STEP     = XLEN'(ILEN_B);

    typedef struct packed {
        xf_phase_e       phase;
        logic [NSTG-1:0] kill;
        logic            redir;
        logic [XLEN-1:0] rpc;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NSTG-1:0] flt_req;
    logic            flt_hit;
    logic [IW-1:0]   flt_idx;
    logic [NSTG-1:0] flt_mask;

    logic accept, old_flt, rfe_go, fault_go, irq_go;
    logic            epc_ld;
    logic [XLEN-1:0] epc_pc0, epc_pc1;
    logic            epc_pc1_vld;

    assign flt_req = stg_vld & stg_exc;

    xf_oldest #(.N(NSTG)) u_old (
        .req  (flt_req),
        .hit  (flt_hit),
        .idx  (flt_idx),
        .thru (flt_mask)
    );

    xf_epc #(.XLEN(XLEN)) u_epc (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld         (epc_ld),
        .ld_pc0     (epc_pc0),
        .ld_pc1     (epc_pc1),
        .ld_pc1_vld (epc_pc1_vld),
        .epc0       (epc0),
        .epc1       (epc1),
        .epc1_vld   (epc1_vld)
    );

    // Event arbitration
    always_comb begin
        accept   = (ctl_q.phase == XF_RUN);
        old_flt  = flt_hit && (flt_idx >= RFE_IDX);
        rfe_go   = accept && rfe_ex && !old_flt;
        fault_go = accept && flt_hit && !rfe_go;
        irq_go   = accept && irq_req && !flt_hit && !rfe_go;
    end

    // Saved-PC load selection
    always_comb begin
        epc_ld      = fault_go || irq_go;
        epc_pc0     = fault_go ? stg_pc[flt_idx] : irq_pc;
        epc_pc1     = slot_tgt[flt_idx];
        epc_pc1_vld = fault_go && stg_slot[flt_idx];
    end

    // Next control state
    always_comb begin
        ctl_d       = '0;
        ctl_d.phase = XF_RUN;
        if (fault_go) begin
            ctl_d.phase = XF_APPLY;
            ctl_d.kill  = flt_mask;
            ctl_d.redir = 1'b1;
            ctl_d.rpc   = HDL_ADDR;
        end else if (irq_go) begin
            ctl_d.phase = XF_APPLY;
            ctl_d.redir = 1'b1;
            ctl_d.rpc   = HDL_ADDR;
        end else if (rfe_go) begin
            ctl_d.phase = XF_RET1;
            ctl_d.kill  = RFE_KILL;
            ctl_d.redir = 1'b1;
            ctl_d.rpc   = epc0;
        end else if (ctl_q.phase == XF_RET1) begin
            ctl_d.redir = 1'b1;
            ctl_d.rpc   = epc1_vld ? epc1 : (epc0 + STEP);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '{phase: XF_RUN, kill: '0, redir: 1'b0, rpc: '0};
        else        ctl_q <= ctl_d;
    end

    assign kill      = ctl_q.kill;
    assign redir_vld = ctl_q.redir;
    assign redir_pc  = ctl_q.rpc;

endmodule

// File: rtl/xf_chk.sv
module xf_chk
    import xf_pkg::*;
#(
    parameter int          XLEN       = 32,
    parameter int          NSTG       = 4,
    parameter logic [31:0] HANDLER_PC = 32'h0000_0180
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSTG-1:0] kill,
    input logic            redir_vld,
    input logic [XLEN-1:0] redir_pc,
    input logic [XLEN-1:0] epc0,
    input logic [XLEN-1:0] epc1,
    input logic            epc1_vld,
    input xf_phase_e       phase
);

    localparam logic [XLEN-1:0] HDL = XLEN'(HANDLER_PC);

    // R2: any squash includes the fetch stage and is contiguous from it
    a_r2_kill_contig: assert property (@(posedge clk) disable iff (!rst_n)
        (kill != '0) |-> (kill[0] && ((kill & (kill + 1'b1)) == '0)));

    // R4: saved PC changes only together with a redirect to the handler
    a_r4_epc_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(epc0) |-> (redir_vld && redir_pc == HDL));

    // R6: interrupt entry never leaves a second restart PC valid
    a_r6_irq_one_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (redir_vld && redir_pc == HDL && kill == '0 && phase == XF_APPLY) |-> !epc1_vld);

    // R7: first return redirect goes to the first saved PC
    a_r7_ret_first: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == XF_RET1) |-> (redir_vld && redir_pc == epc0));

    // R8: a second redirect always follows the first return redirect
    a_r8_ret_second: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == XF_RET1) |=> redir_vld);

    // R10: saved PCs hold while a flush is being applied
    a_r10_hold_apply: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != XF_RUN) |=> ($stable(epc0) && $stable(epc1) && $stable(epc1_vld)));

endmodule

bind exc_flush_ctl xf_chk #(
    .XLEN       (XLEN),
    .NSTG       (NSTG),
    .HANDLER_PC (HANDLER_PC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .kill      (kill),
    .redir_vld (redir_vld),
    .redir_pc  (redir_pc),
    .epc0      (epc0),
    .epc1      (epc1),
    .epc1_vld  (epc1_vld),
    .phase     (ctl_q.phase)
);

// File: tb/exc_flush_ctl_tb.sv
module exc_flush_ctl_tb;

    localparam int XLEN = 32;
    localparam int NSTG = 4;
    localparam logic [31:0] HDL = 32'h0000_0180;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic [NSTG-1:0]           stg_vld = '0;
    logic [NSTG-1:0]           stg_exc = '0;
    logic [NSTG-1:0][XLEN-1:0] stg_pc = '0;
    logic [NSTG-1:0]           stg_slot = '0;
    logic [NSTG-1:0][XLEN-1:0] slot_tgt = '0;
    logic                      irq_req = 1'b0;
    logic [XLEN-1:0]           irq_pc = '0;
    logic                      rfe_ex = 1'b0;
    logic [NSTG-1:0]           kill;
    logic                      redir_vld;
    logic [XLEN-1:0]           redir_pc;
    logic [XLEN-1:0]           epc0;
    logic [XLEN-1:0]           epc1;
    logic                      epc1_vld;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    exc_flush_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .stg_vld(stg_vld), .stg_exc(stg_exc),
        .stg_pc(stg_pc), .stg_slot(stg_slot), .slot_tgt(slot_tgt),
        .irq_req(irq_req), .irq_pc(irq_pc), .rfe_ex(rfe_ex),
        .kill(kill), .redir_vld(redir_vld), .redir_pc(redir_pc),
        .epc0(epc0), .epc1(epc1), .epc1_vld(epc1_vld)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic clr_in();
        stg_vld = '0; stg_exc = '0; stg_slot = '0;
        irq_req = 1'b0; rfe_ex = 1'b0;
    endtask

    // Inputs set at a falling edge are seen by one rising edge, then cleared.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        clr_in();
    endtask

    task automatic set_pcs();
        for (int i = 0; i < NSTG; i++) begin
            stg_pc[i]   = 32'h1000 + 32'(i) * 32'h10;
            slot_tgt[i] = 32'h8000 + 32'(i) * 32'h100;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic t_reset();
        chk("R1", "kill", 32'(kill), 0);
        chk("R1", "redir_vld", 32'(redir_vld), 0);
        chk("R1", "epc0", epc0, 0);
        chk("R1", "epc1_vld", 32'(epc1_vld), 0);
    endtask

    task automatic t_fault_id();
        stg_vld = 4'b1111; stg_exc = 4'b0010;
        step();
        chk("R2", "kill id", 32'(kill), 32'h3);
        chk("R2", "redir_vld", 32'(redir_vld), 1);
        chk("R2", "redir_pc", redir_pc, HDL);
        chk("R4", "epc0 id", epc0, 32'h1010);
        chk("R4", "epc1_vld", 32'(epc1_vld), 0);
        idle(1);
    endtask

    task automatic t_oldest();
        // MEM fault with valid low must be ignored; EX and IF fault together
        stg_vld = 4'b0111; stg_exc = 4'b1101;
        step();
        chk("R3", "kill oldest", 32'(kill), 32'h7);
        chk("R3", "epc0 oldest", epc0, 32'h1020);
        idle(1);
        stg_vld = 4'b1111; stg_exc = 4'b1111;
        step();
        chk("R3", "kill all", 32'(kill), 32'hF);
        chk("R3", "epc0 mem", epc0, 32'h1030);
        idle(1);
    endtask

    task automatic t_slot_and_rfe();
        stg_vld = 4'b1111; stg_exc = 4'b0100; stg_slot = 4'b0100;
        step();
        chk("R5", "epc0 slot", epc0, 32'h1020);
        chk("R5", "epc1", epc1, 32'h8200);
        chk("R5", "epc1_vld", 32'(epc1_vld), 1);
        idle(1);
        rfe_ex = 1'b1;
        step();
        chk("R7", "kill rfe", 32'(kill), 32'h3);
        chk("R7", "redir first", redir_pc, 32'h1020);
        step();
        chk("R8", "second vld", 32'(redir_vld), 1);
        chk("R8", "second to epc1", redir_pc, 32'h8200);
        step();
        chk("R8", "third quiet", 32'(redir_vld), 0);
    endtask

    task automatic t_rfe_seq();
        stg_vld = 4'b1111; stg_exc = 4'b1000;
        step();
        chk("R4", "epc1_vld cleared", 32'(epc1_vld), 0);
        idle(1);
        rfe_ex = 1'b1;
        step();
        chk("R7", "redir first seq", redir_pc, 32'h1030);
        step();
        chk("R8", "seq redirect", redir_pc, 32'h1034);
        chk("R8", "seq vld", 32'(redir_vld), 1);
        idle(1);
    endtask

    task automatic t_irq();
        irq_req = 1'b1; irq_pc = 32'h4444;
        step();
        chk("R6", "irq kill", 32'(kill), 0);
        chk("R6", "irq redir", redir_pc, HDL);
        chk("R6", "irq epc0", epc0, 32'h4444);
        chk("R6", "irq epc1_vld", 32'(epc1_vld), 0);
        idle(1);
        irq_req = 1'b1; irq_pc = 32'h5555; stg_vld = 4'b0001; stg_exc = 4'b0001;
        step();
        chk("R6", "fault beats irq", epc0, 32'h1000);
        chk("R6", "fault beats irq kill", 32'(kill), 32'h1);
        idle(1);
    endtask

    task automatic t_rfe_priority();
        rfe_ex = 1'b1; stg_vld = 4'b1111; stg_exc = 4'b1000;
        step();
        chk("R9", "mem fault over rfe", redir_pc, HDL);
        chk("R9", "mem fault kill", 32'(kill), 32'hF);
        idle(1);
        rfe_ex = 1'b1; stg_vld = 4'b1111; stg_exc = 4'b0001;
        step();
        chk("R9", "rfe over if fault", redir_pc, 32'h1030);
        chk("R9", "epc0 kept", epc0, 32'h1030);
        idle(2);
    endtask

    task automatic t_ignore_apply();
        stg_vld = 4'b1111; stg_exc = 4'b0100; stg_slot = 4'b0100;
        step();
        // apply cycle: inject more events
        stg_vld = 4'b1111; stg_exc = 4'b1000; irq_req = 1'b1; irq_pc = 32'h7777;
        rfe_ex = 1'b1;
        step();
        chk("R10", "epc0 held", epc0, 32'h1020);
        chk("R10", "epc1_vld held", 32'(epc1_vld), 1);
        chk("R10", "no redirect", 32'(redir_vld), 0);
        idle(1);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        set_pcs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fault_id();
        t_oldest();
        t_slot_and_rfe();
        t_rfe_seq();
        t_irq();
        t_rfe_priority();
        t_ignore_apply();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule